// File: doc/BRIEF.md
# Double-Buffered Read-Only Serial Slave

This block keeps five bytes of decoded line data in two banks. A receive bank is filled a byte at a time by upstream logic. A transmit bank holds the snapshot that a two-wire (I2C) bus master can read. The block answers only read requests, and only as a slave transmitter. It recognises one of four 7-bit addresses, chosen by two strap inputs. SDA is driven as an open drain: the block only ever pulls it low.

A one-cycle `data_valid` strobe copies the receive bank into the transmit bank and marks the data as new. If a transaction addressed to this slave is open, the copy is held back until the next start or stop condition on the bus, so a master never sees a byte pair that is torn across two snapshots. New data can be read once. At the stop that closes a read in which at least one byte went out, the new-data flag drops, and from then on every byte read is FFh until the next snapshot arrives.

SCL and SDA each pass through a two-flop synchroniser and a stability counter. Pulses shorter than `FILT_CYCLES` system clocks never reach the protocol logic. The default of 10 cycles is 200 ns at 50 MHz.

Top module: `dl_readout_slave`

## Requirements
- R1: The slave acknowledges an address byte only when its upper seven bits equal {5'b00100, addr_sel[1], addr_sel[0]} and its LSB (read/write bit) is 1. Any other address byte, and any write request, is left unacknowledged with SDA released.
- R2: Within one read, the bytes come out in the order of receive slots 1, 2, 3, 4, then 0. Every byte after the fifth repeats slot 0.
- R3: Each byte is shifted out MSB first. The slave changes SDA only while SCL is low.
- R4: A `data_valid` pulse copies the receive bank to the transmit bank at once when no addressed transaction is open. While one is open, the copy waits for the next start or stop, and bytes still read in that transaction come from the old snapshot.
- R5: The new-data flag clears at the stop that ends a read in which at least one data byte was sent. Later reads return FFh until a new snapshot is copied. A copy at that same stop takes priority and sets the flag.
- R6: After reset, and before any copy, every byte read is FFh.
- R7: While `rst_n` is low, `sda_oe` stays 0 and no acknowledge is given.
- R8: A pulse shorter than `FILT_CYCLES` clocks on SCL or SDA has no effect on the transfer.
- R9: When the master does not acknowledge a byte, SDA is released and stays released until the next start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_sel | input | 2 | Address strap bits, the two LSBs of the 7-bit address |
| rx_we | input | 1 | Write enable for one byte of the receive bank |
| rx_sel | input | 3 | Receive slot written (0 to 4) |
| rx_byte | input | 8 | Byte written into the selected receive slot |
| data_valid | input | 1 | Strobe: copy the receive bank to the transmit bank |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
The hardest case to reach is a snapshot that arrives while the slave is partway through a read. The bench reads two bytes of one snapshot, loads a second snapshot and strobes `data_valid` between bytes, then finishes the read. It then checks two things: the remaining bytes come from the first snapshot, and the very stop that clears the flag also promotes the second snapshot. Filter behaviour is tested by injecting sub-threshold pulses on SCL and on SDA during the high phase of data bits. An SCL pulse that got through would shift in an extra bit. An SDA pulse that got through would look like a start condition. Either one would corrupt the bytes that are read back.

// File: rtl/dl_readout_slave.sv
module dl_readout_slave #(
  parameter int FILT_CYCLES = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr_sel,
  input  logic       rx_we,
  input  logic [2:0] rx_sel,
  input  logic [7:0] rx_byte,
  input  logic       data_valid,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam int FW = $clog2(FILT_CYCLES + 1);
  localparam logic [4:0] ADDR_HI = 5'b00100;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_TX, S_MACK, S_WAIT} state_t;

  wire [1:0] raw = {sda_i, scl_i};
  logic [1:0] filt, synced;

  for (genvar g = 0; g < 2; g++) begin : g_flt
    logic m0, m1, f;
    logic [FW-1:0] c;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m0 <= 1'b1; m1 <= 1'b1; f <= 1'b1; c <= '0;
      end else begin
        m0 <= raw[g];
        m1 <= m0;
        if (m1 == f) c <= '0;
        else if (c == FW'(FILT_CYCLES - 1)) begin
          f <= m1;
          c <= '0;
        end else c <= c + 1'b1;
      end
    end
    assign filt[g]   = f;
    assign synced[g] = m1;
  end

  wire scl_f = filt[0];
  wire sda_f = filt[1];
  logic scl_d, sda_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin scl_d <= 1'b1; sda_d <= 1'b1; end
    else begin scl_d <= scl_f; sda_d <= sda_f; end

  wire start_det = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;
  wire scl_rise  = scl_f & ~scl_d;
  wire scl_fall  = ~scl_f & scl_d;
  wire bus_evt   = start_det | stop_det;

  state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic [2:0] pos;
  logic m_nack, addressed, pending, newdata, sent_any;
  logic [4:0][7:0] rx_bank, tx_bank;

  wire [2:0] sel      = (pos == 3'd4) ? 3'd0 : pos + 3'd1;
  wire [7:0] out_byte = newdata ? tx_bank[sel] : 8'hFF;
  wire do_copy = (data_valid & ~addressed) | ((pending | data_valid) & bus_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; bitcnt <= '0; shreg <= '0; pos <= '0;
      m_nack <= 1'b0; addressed <= 1'b0; sent_any <= 1'b0; sda_oe <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR; bitcnt <= '0; pos <= '0; sda_oe <= 1'b0; addressed <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; sda_oe <= 1'b0; addressed <= 1'b0; sent_any <= 1'b0;
    end else begin
      case (state)
        S_ADDR: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end else if (scl_fall && bitcnt == 4'd8) begin
            if (shreg == {ADDR_HI, addr_sel, 1'b1}) begin
              sda_oe <= 1'b1; addressed <= 1'b1; state <= S_AACK;
            end else state <= S_WAIT;
          end
        end
        S_AACK, S_MACK: begin
          if (scl_rise) m_nack <= sda_f;
          if (scl_fall) begin
            if (state == S_MACK && m_nack) begin
              state <= S_WAIT; sda_oe <= 1'b0;
            end else begin
              shreg <= out_byte; sda_oe <= ~out_byte[7];
              bitcnt <= 4'd7; state <= S_TX;
            end
          end
        end
        S_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd0) begin
              sda_oe <= 1'b0; state <= S_MACK; sent_any <= 1'b1;
              if (pos != 3'd4) pos <= pos + 3'd1;
            end else begin
              sda_oe <= ~shreg[6];
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt - 4'd1;
            end
          end
        end
        default: sda_oe <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_bank <= '0; tx_bank <= '0; newdata <= 1'b0; pending <= 1'b0;
    end else begin
      if (rx_we && rx_sel <= 3'd4) rx_bank[rx_sel] <= rx_byte;
      pending <= (pending | (data_valid & addressed)) & ~bus_evt;
      if (do_copy) begin
        tx_bank <= rx_bank;
        newdata <= 1'b1;
      end else if (stop_det && sent_any) newdata <= 1'b0;
    end
  end

  p_no_write_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && scl_fall && bitcnt == 4'd8 && !shreg[0] && !bus_evt) |=> !sda_oe);
  p_drive_while_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  p_hold_snapshot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addressed && !bus_evt) |=> $stable(tx_bank));
  p_flag_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(newdata) |-> $past(stop_det));
  p_filter_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_f) |-> $past(synced[0]));
  p_released_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT) |-> !sda_oe);
endmodule

// File: tb/dl_readout_slave_bench.sv
module dl_readout_slave_bench;
  localparam int H = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] addr_sel = 2'b10;
  logic rx_we = 1'b0, data_valid = 1'b0;
  logic [2:0] rx_sel = '0;
  logic [7:0] rx_byte = '0;
  logic m_scl = 1'b1, m_sda = 1'b1, g_scl = 1'b0, g_sda = 1'b0;
  logic sda_oe;
  wire sda_line = m_sda & ~sda_oe;
  wire scl_i = m_scl & ~g_scl;
  wire sda_i = sda_line & ~g_sda;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dl_readout_slave u_dl_readout_slave (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .rx_we(rx_we), .rx_sel(rx_sel),
    .rx_byte(rx_byte), .data_valid(data_valid), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe));

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic bstart();
    m_sda = 1'b1; w(H); m_scl = 1'b1; w(H); m_sda = 1'b0; w(H); m_scl = 1'b0; w(H);
  endtask
  task automatic bstop();
    m_sda = 1'b0; w(H); m_scl = 1'b1; w(H); m_sda = 1'b1; w(H);
  endtask
  task automatic wbit(input logic b);
    m_sda = b; w(H); m_scl = 1'b1; w(H); m_scl = 1'b0;
  endtask
  task automatic rbit(input bit glitch, output logic b);
    m_sda = 1'b1; w(H); m_scl = 1'b1;
    if (glitch) begin
      w(4); g_scl = 1'b1; w(4); g_scl = 1'b0; w(4);
      if (sda_line) g_sda = 1'b1;
      w(4); g_sda = 1'b0; w(4);
    end else w(H/2);
    b = sda_line; w(H/2); m_scl = 1'b0;
  endtask
  task automatic sbyte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(v[i]);
    rbit(1'b0, b); ack = ~b;
  endtask
  task automatic rbyte(input bit glitch, input bit ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(glitch, b); v[i] = b; end
    wbit(~ack);
  endtask

  task automatic load(input logic [4:0][7:0] d, input bit strobe);
    for (int i = 0; i < 5; i++) begin
      rx_we = 1'b1; rx_sel = 3'(i); rx_byte = d[i]; w(1);
    end
    rx_we = 1'b0;
    if (strobe) begin data_valid = 1'b1; w(1); data_valid = 1'b0; end
    w(2);
  endtask

  task automatic read_n(input int n, input bit glitch, input logic [7:0] e0, input logic [7:0] e1,
                        input logic [7:0] e2, input logic [7:0] e3, input logic [7:0] e4,
                        input logic [7:0] erep, input string req);
    logic a; logic [7:0] v; logic [7:0] e;
    bstart(); sbyte(8'h25, a); chk({req, " addr ack"}, 8'(a), 8'd1);
    for (int i = 0; i < n; i++) begin
      e = (i == 0) ? e0 : (i == 1) ? e1 : (i == 2) ? e2 : (i == 3) ? e3 : (i == 4) ? e4 : erep;
      rbyte(glitch, i != n - 1, v);
      chk(req, v, e);
    end
    bstop();
  endtask

  task automatic t_reset_r7();
    logic a; int seen = 0;
    bstart();
    fork
      sbyte(8'h25, a);
      repeat (9 * 2 * H) begin @(negedge clk); if (sda_oe) seen++; end
    join
    bstop();
    chk("R7 no ack in reset", 8'(a), 8'd0);
    chk("R7 sda_oe held 0", 8'(seen), 8'd0);
    rst_n = 1'b1; w(20);
  endtask

  task automatic t_after_reset_r6();
    read_n(5, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R6 empty after reset");
  endtask

  task automatic t_order_r2();
    load({8'h01, 8'hC3, 8'h3C, 8'h81, 8'h5A}, 1'b1);
    // R2 order, R3 MSB first (slot 4 byte 01h), R4 immediate copy
    read_n(7, 1'b0, 8'h81, 8'h3C, 8'hC3, 8'h01, 8'h5A, 8'h5A, "R2 R3 R4 order");
  endtask

  task automatic t_once_r5();
    read_n(3, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 read once");
  endtask

  task automatic t_addr_r1();
    logic a;
    bstart(); sbyte(8'h27, a); bstop(); chk("R1 wrong strap", 8'(a), 8'd0);
    bstart(); sbyte(8'h24, a); bstop(); chk("R1 write request", 8'(a), 8'd0);
    bstart(); sbyte(8'h45, a); bstop(); chk("R1 other address", 8'(a), 8'd0);
    addr_sel = 2'b01;
    bstart(); sbyte(8'h23, a);
    begin logic [7:0] v; rbyte(1'b0, 1'b0, v); end
    bstop(); chk("R1 strap 01 ack", 8'(a), 8'd1);
    addr_sel = 2'b10;
  endtask

  task automatic t_defer_r4();
    logic a; logic [7:0] v;
    load({8'h44, 8'h33, 8'h22, 8'h11, 8'h55}, 1'b1);
    bstart(); sbyte(8'h25, a); chk("R4 addr ack", 8'(a), 8'd1);
    rbyte(1'b0, 1'b1, v); chk("R4 old byte 1", v, 8'h11);
    rbyte(1'b0, 1'b1, v); chk("R4 old byte 2", v, 8'h22);
    load({8'hE4, 8'hE3, 8'hE2, 8'hE1, 8'hE0}, 1'b1);
    rbyte(1'b0, 1'b1, v); chk("R4 held byte 3", v, 8'h33);
    rbyte(1'b0, 1'b1, v); chk("R4 held byte 4", v, 8'h44);
    rbyte(1'b0, 1'b0, v); chk("R4 held byte 5", v, 8'h55);
    bstop();
    read_n(5, 1'b0, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE0, 8'hE0, "R4 R5 copy at stop");
  endtask

  task automatic t_nack_r9();
    logic a; logic [7:0] v, rest;
    load({8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b1);
    bstart(); sbyte(8'h25, a);
    rbyte(1'b0, 1'b0, v); chk("R9 first byte", v, 8'h00);
    rbyte(1'b0, 1'b0, rest); chk("R9 released after nack", rest, 8'hFF);
    bstop();
    read_n(2, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, "R5 after one byte");
  endtask

  task automatic t_glitch_r8();
    load({8'h0F, 8'hF0, 8'h96, 8'h69, 8'hA5}, 1'b1);
    read_n(5, 1'b1, 8'h69, 8'h96, 8'hF0, 8'h0F, 8'hA5, 8'hA5, "R8 glitch filter");
  endtask

  initial begin
    w(10);
    t_reset_r7();
    t_after_reset_r6();
    t_order_r2();
    t_once_r5();
    t_addr_r1();
    t_defer_r4();
    t_nack_r9();
    t_glitch_r8();
    w(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule